// File: doc/BRIEF.md
# Interlaced Field and Vertical Blanking Flag Generator

This block tracks the line position inside an interlaced video frame and produces two per-line flags: a field flag that tells the first field from the second, and a vertical blanking flag that marks lines that carry no active picture. It handles the 525-line (60 Hz) and 625-line (50 Hz) systems. An input selects the system, and the block samples that input only when a frame starts. A timing front end drives one strobe at the start of each line and another at the start of each frame. Downstream logic reads the current line number and the two flags.

Vertical blanking can follow a fixed table for each standard. It can also follow a programmable window that a start line and a stop line bound, and a 3-bit mode input chooses between the two. The window may wrap across the end of the frame. All outputs are registered. They update together in the clock after a strobe and hold their values between strobes.

Top module: `vfield_flag_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls when no strobe has arrived, `line_num` is 1, `fld_f` is 1 and `vblk_v` is 1. The active standard after reset is 525-line.
- R2: Each `line_stb` that has no `frame_stb` with it and arrives below the last line raises `line_num` by one.
- R3: A `line_stb` that arrives on the last line of the active standard returns `line_num` to 1. The last line is 525 when the active standard is 525-line, and 625 when it is 625-line.
- R4: `frame_stb` forces `line_num` to 1. It takes priority over a `line_stb` in the same cycle.
- R5: The active standard loads from `std_sel` (0 = 525-line, 1 = 625-line) only on `frame_stb`. A change of `std_sel` inside a frame does not move the wrap point of that frame.
- R6: In 525-line mode, `fld_f` is 1 on lines 1–3 and 266–525, and 0 on lines 4–265.
- R7: In 525-line mode with `vmode` = 000, `vblk_v` is 1 on lines 1–19 and 264–282, and 0 on all other lines.
- R8: In 625-line mode, `fld_f` is 0 on lines 1–312 and 1 on lines 313–625.
- R9: In 625-line mode with `vmode` = 000, `vblk_v` is 1 on lines 1–22, 311–335 and 624–625, and 0 on all other lines.
- R10: With `vmode` nonzero and `gate_start` <= `gate_stop`, `vblk_v` is 1 exactly when `gate_start` <= line < `gate_stop`. When the two values are equal, the window is empty.
- R11: With `vmode` nonzero and `gate_start` > `gate_stop`, `vblk_v` is 1 when line >= `gate_start` or line < `gate_stop`, so the window wraps across the end of the frame.
- R12: `line_num`, `fld_f` and `vblk_v` change only in the clock after a strobe, all three at the same time. The flags describe the new line and use the `vmode`, `gate_start` and `gate_stop` values present at the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse at the start of each line |
| frame_stb | input | 1 | One-cycle pulse at the start of each frame |
| std_sel | input | 1 | Standard request: 0 = 525-line, 1 = 625-line |
| vmode | input | 3 | 000 = fixed blanking table, nonzero = programmable window |
| gate_start | input | LW | First line inside the programmable window |
| gate_stop | input | LW | First line after the programmable window |
| line_num | output | LW | Current line number, counted from 1 |
| fld_f | output | 1 | Field flag for the current line |
| vblk_v | output | 1 | Vertical blanking flag for the current line |

## Verification
The bench walks through complete frames of both standards. It checks every table edge (lines 3/4, 19/20, 263/264, 282/283, 265/266, 22/23, 310/311, 312/313, 335/336 and 623/624) and both wrap points. A design with an off-by-one edge gives a wrong flag on exactly one line. A design that latches the standard request at once wraps a 525-line frame at 625, or the reverse, after a mid-frame change of `std_sel`. The bench also drives both strobes in the same cycle, which catches a design that gives the line strobe priority. Windows that wrap and windows whose start equals their stop expose a design that treats the stop line as inclusive or ignores the wrap. Idle cycles between strobes show up outputs that drift when no strobe arrives.

// File: rtl/vfield_pkg.sv
package vfield_pkg;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } vstd_e;

    typedef struct packed {
        logic f;
        logic v;
    } vflags_t;

    localparam int unsigned LINES_525 = 525;
    localparam int unsigned LINES_625 = 625;

    function automatic int unsigned frame_len(vstd_e s);
        return (s == STD_625) ? LINES_625 : LINES_525;
    endfunction

    function automatic logic fixed_field(vstd_e s, int unsigned ln);
        if (s == STD_625)
            return ln >= 313;
        return (ln <= 3) || (ln >= 266);
    endfunction

    function automatic logic fixed_blank(vstd_e s, int unsigned ln);
        if (s == STD_625)
            return (ln <= 22) || ((ln >= 311) && (ln <= 335)) || (ln >= 624);
        return (ln <= 19) || ((ln >= 264) && (ln <= 282));
    endfunction

    function automatic logic gate_blank(int unsigned ln, int unsigned st, int unsigned sp);
        if (st <= sp)
            return (ln >= st) && (ln < sp);
        return (ln >= st) || (ln < sp);
    endfunction

endpackage

// File: rtl/vfield_line_counter.sv
module vfield_line_counter
    import vfield_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_stb,
    input  logic          frame_stb,
    input  logic          std_sel,
    output logic [LW-1:0] line_q,
    output vstd_e         std_q,
    output logic [LW-1:0] line_d,
    output vstd_e         std_d
);

    localparam logic [LW-1:0] FIRST_LINE = LW'(1);

    logic at_last;

    assign at_last = int'(line_q) >= frame_len(std_q);

    always_comb begin
        line_d = line_q;
        std_d  = std_q;
        if (frame_stb) begin
            line_d = FIRST_LINE;
            std_d  = vstd_e'(std_sel);
        end else if (line_stb) begin
            line_d = at_last ? FIRST_LINE : line_q + FIRST_LINE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= FIRST_LINE;
            std_q  <= STD_525;
        end else begin
            line_q <= line_d;
            std_q  <= std_d;
        end
    end

endmodule

// File: rtl/vfield_flag_decode.sv
module vfield_flag_decode
    import vfield_pkg::*;
#(
    parameter int LW     = 10,
    parameter int MW     = 3,
    parameter bit GATE_EN = 1'b1
) (
    input  logic [LW-1:0] line_in,
    input  vstd_e         std_in,
    input  logic [MW-1:0] vmode,
    input  logic [LW-1:0] gate_start,
    input  logic [LW-1:0] gate_stop,
    output vflags_t       flags
);

    logic blank_fixed;
    logic blank_sel;

    assign blank_fixed = fixed_blank(std_in, int'(line_in));

    generate
        if (GATE_EN) begin : g_gate
            logic blank_gate;
            assign blank_gate = gate_blank(int'(line_in), int'(gate_start), int'(gate_stop));
            assign blank_sel  = (vmode != '0) ? blank_gate : blank_fixed;
        end else begin : g_fixed
            logic unused_ok;
            assign unused_ok = ^{vmode, gate_start, gate_stop};
            assign blank_sel = blank_fixed;
        end
    endgenerate

    always_comb begin
        flags.f = fixed_field(std_in, int'(line_in));
        flags.v = blank_sel;
    end

endmodule

// File: rtl/vfield_flag_gen.sv
module vfield_flag_gen
    import vfield_pkg::*;
#(
    parameter int LW      = 10,
    parameter int MW      = 3,
    parameter bit GATE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_stb,
    input  logic          frame_stb,
    input  logic          std_sel,
    input  logic [MW-1:0] vmode,
    input  logic [LW-1:0] gate_start,
    input  logic [LW-1:0] gate_stop,
    output logic [LW-1:0] line_num,
    output logic          fld_f,
    output logic          vblk_v
);

    logic [LW-1:0] line_next;
    vstd_e         std_next;
    vstd_e         act_std;
    vflags_t       flags_next;
    vflags_t       flags_q;

    vfield_line_counter #(.LW(LW)) i_cnt (
        .clk       (clk),
        .rst       (rst),
        .line_stb  (line_stb),
        .frame_stb (frame_stb),
        .std_sel   (std_sel),
        .line_q    (line_num),
        .std_q     (act_std),
        .line_d    (line_next),
        .std_d     (std_next)
    );

    vfield_flag_decode #(.LW(LW), .MW(MW), .GATE_EN(GATE_EN)) i_dec (
        .line_in    (line_next),
        .std_in     (std_next),
        .vmode      (vmode),
        .gate_start (gate_start),
        .gate_stop  (gate_stop),
        .flags      (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '{f: 1'b1, v: 1'b1};
        else if (line_stb || frame_stb)
            flags_q <= flags_next;
    end

    assign fld_f  = flags_q.f;
    assign vblk_v = flags_q.v;

endmodule

// File: rtl/vfield_chk.sv
module vfield_chk
    import vfield_pkg::*;
#(
    parameter int LW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          line_stb,
    input logic          frame_stb,
    input logic [LW-1:0] line_num,
    input logic          fld_f,
    input logic          vblk_v,
    input vstd_e         act_std
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (line_num == LW'(1)) && fld_f && vblk_v);

    // R2
    line_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !frame_stb && (int'(line_num) < frame_len(act_std)))
        |=> line_num == $past(line_num) + LW'(1));

    // R3
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !frame_stb && (int'(line_num) == frame_len(act_std)))
        |=> line_num == LW'(1));

    // R4
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> line_num == LW'(1));

    // R5
    std_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(act_std));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_stb && !frame_stb) |=> ($stable(line_num) && $stable(fld_f) && $stable(vblk_v)));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        (line_num != '0) && (int'(line_num) <= frame_len(act_std)));

endmodule

bind vfield_flag_gen vfield_chk #(.LW(LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_stb  (line_stb),
    .frame_stb (frame_stb),
    .line_num  (line_num),
    .fld_f     (fld_f),
    .vblk_v    (vblk_v),
    .act_std   (act_std)
);

// File: tb/test_vfield_flag_gen.sv
`timescale 1ns/1ps
module test_vfield_flag_gen;

    localparam int LW = 10;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_stb = 1'b0;
    logic          frame_stb = 1'b0;
    logic          std_sel = 1'b0;
    logic [MW-1:0] vmode = '0;
    logic [LW-1:0] gate_start = '0;
    logic [LW-1:0] gate_stop = '0;
    logic [LW-1:0] line_num;
    logic          fld_f;
    logic          vblk_v;

    int vectors = 0;
    int fails = 0;

    int m_line = 1;
    int m_std = 0;
    bit m_f = 1'b1;
    bit m_v = 1'b1;

    always #10 clk = ~clk;

    vfield_flag_gen #(.LW(LW), .MW(MW)) i_vfield_flag_gen (
        .clk(clk), .rst(rst), .line_stb(line_stb), .frame_stb(frame_stb),
        .std_sel(std_sel), .vmode(vmode), .gate_start(gate_start),
        .gate_stop(gate_stop), .line_num(line_num), .fld_f(fld_f), .vblk_v(vblk_v)
    );

    function automatic int lines_of(int s);
        return s ? 625 : 525;
    endfunction

    function automatic bit want_f(int s, int l);
        if (s) return l > 312;
        return !(l >= 4 && l <= 265);
    endfunction

    function automatic bit want_v_fixed(int s, int l);
        if (s) return (l < 23) || (l > 310 && l < 336) || (l > 623);
        return (l < 20) || (l > 263 && l < 283);
    endfunction

    function automatic bit want_v_gate(int l, int a, int b);
        if (a > b) return !(l >= b && l < a);
        return (l >= a) && (l < b);
    endfunction

    task automatic compare(string lt, string ft, string vt);
        vectors++;
        if (int'(line_num) != m_line) begin
            fails++;
            $display("FAIL %s line_num actual=%0d expected=%0d", lt, line_num, m_line);
        end
        if (fld_f !== m_f) begin
            fails++;
            $display("FAIL %s fld_f line=%0d actual=%0b expected=%0b", ft, m_line, fld_f, m_f);
        end
        if (vblk_v !== m_v) begin
            fails++;
            $display("FAIL %s vblk_v line=%0d actual=%0b expected=%0b", vt, m_line, vblk_v, m_v);
        end
    endtask

    task automatic step(bit ls, bit fs, string over);
        string lt, ft, vt;
        line_stb  = ls;
        frame_stb = fs;
        @(negedge clk);
        line_stb  = 1'b0;
        frame_stb = 1'b0;
        if (fs) begin
            lt = "R4";
        end else if (ls) begin
            lt = (m_line >= lines_of(m_std)) ? "R3" : "R2";
        end else begin
            lt = "R12";
        end
        if (fs) begin
            m_std  = int'(std_sel);
            m_line = 1;
        end else if (ls) begin
            m_line = (m_line >= lines_of(m_std)) ? 1 : m_line + 1;
        end
        if (fs || ls) begin
            m_f = want_f(m_std, m_line);
            if (vmode != '0)
                m_v = want_v_gate(m_line, int'(gate_start), int'(gate_stop));
            else
                m_v = want_v_fixed(m_std, m_line);
            ft = m_std ? "R8" : "R6";
            if (vmode != '0)
                vt = (gate_start > gate_stop) ? "R11" : "R10";
            else
                vt = m_std ? "R9" : "R7";
        end else begin
            ft = "R12";
            vt = "R12";
        end
        if (over != "") begin
            lt = over;
            ft = over;
            vt = over;
        end
        compare(lt, ft, vt);
    endtask

    task automatic run_frame(int sel, int n);
        std_sel = sel[0];
        step(1'b0, 1'b1, "");
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, "");
            if (i % 37 == 5) step(1'b0, 1'b0, "");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        compare("R1", "R1", "R1");
        rst = 1'b0;
        step(1'b0, 1'b0, "R1");

        // R6 R7: full 525 frame with fixed table, including wrap
        run_frame(0, 530);

        // R5: change the request mid-frame; wrap stays at 525
        std_sel = 1'b0;
        step(1'b0, 1'b1, "");
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0, "");
        std_sel = 1'b1;
        for (int i = 0; i < 430; i++) step(1'b1, 1'b0, "R5");

        // R8 R9: full 625 frame
        run_frame(1, 630);

        // R4: both strobes at once, frame wins
        for (int i = 0; i < 50; i++) step(1'b1, 1'b0, "");
        step(1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, "R4");

        // R10: plain window
        vmode = 3'b101; gate_start = 10'd20; gate_stop = 10'd40;
        run_frame(1, 630);
        // R11: wrapped window
        vmode = 3'b001; gate_start = 10'd600; gate_stop = 10'd10;
        run_frame(1, 630);
        // R10: empty window
        vmode = 3'b111; gate_start = 10'd100; gate_stop = 10'd100;
        run_frame(0, 530);
        vmode = 3'b000;

        // random mix
        for (int i = 0; i < 5000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 199) == 0) std_sel = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 299) == 0) vmode = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 299) == 0) begin
                gate_start = 10'($urandom_range(1, 625));
                gate_stop  = 10'($urandom_range(1, 625));
            end
            if (r < 2) step(1'b0, 1'b1, "");
            else if (r < 3) step(1'b1, 1'b1, "");
            else if (r < 75) step(1'b1, 1'b0, "");
            else step(1'b0, 1'b0, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule